// File: doc/BRIEF.md
# Eight-Source Two-Level Interrupt Controller

This block gathers eight interrupt requests and tells the processor core which one to service next. Four requests come from active-low external pins, three from timer overflows and one from the serial port. The timer and serial requests arrive as plain level inputs. The external pins are synchronised. Each external source can be set to trigger on a falling edge, which latches a pending flag, or on a low level, where the flag simply follows the pin.

The winning request is chosen in two steps. A high-priority request always beats a low-priority one. Between requests of the same level, the lower source index wins. The block presents the winner to the core with a request line and an 8-bit vector. The core answers with an acknowledge when it enters the handler and a return strobe when it leaves.

A two-entry in-service record allows a high-priority request to interrupt a low-priority handler. No request interrupts a handler of its own level, and nothing interrupts a high-priority handler. One bit-addressable control register belongs to the two added external sources. It holds their trigger types, pending flags, enables and priorities. The enables, priorities and trigger types of the other sources arrive as plain inputs.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset, `irq_req` is 0 and `xc_rdata` reads 0x00.
- R2: With its type bit at 1, an external source sets its pending flag on a falling edge of its synchronised pin. A pin that stays low does not set the flag again. The flags of sources 6 and 7 read back in `xc_rdata` bit 1 and bit 5.
- R3: With its type bit at 0, an external source's pending flag equals the inverted synchronised pin, and an acknowledge does not clear it.
- R4: The vector for source i is 8*i+3. Index 0 is external 0, 1 is timer 0, 2 is external 1, 3 is timer 1, 4 is serial, 5 is timer 2, 6 is external 2 and 7 is external 3.
- R5: Among pending, enabled requests of the same priority level, the lowest index is presented.
- R6: A pending, enabled high-priority request is presented ahead of any low-priority one, whatever their indices. The priority bits are `ip_main[5:0]` for sources 0-5, `xc` bit 3 for source 6 and `xc` bit 7 for source 7.
- R7: No request is presented while `ie_main[7]` is 0. Source i (i<6) needs `ie_main[i]`, source 6 needs `xc` bit 2 and source 7 needs `xc` bit 6.
- R8: While a low-priority handler is in service, only high-priority requests are presented. While a high-priority handler is in service, nothing is presented.
- R9: `irq_reti` ends the most recently entered handler. Requests that it was blocking are then presented again.
- R10: An acknowledge of an edge-mode external source clears that source's pending flag.
- R11: A byte write replaces all eight `xc` bits. A bit write changes only bit `xc_bit_sel`. Both kinds of write can set or clear the edge-mode pending flags. The bit order from 7 down to 0 is priority-7, enable-7, flag-7, type-7, priority-6, enable-6, flag-6, type-6.
- R12: In the cycle after an accepted `irq_ack`, `irq_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_n | input | 4 | External request pins, active low: external 0, 1, 2, 3 |
| tmr_req | input | 3 | Timer 0, 1, 2 overflow requests (level) |
| ser_req | input | 1 | Serial port request (level) |
| ext01_type | input | 2 | Trigger type of external 0 and 1 (1 = falling edge) |
| ie_main | input | 8 | Bit 7 global enable, bits 5:0 source enables |
| ip_main | input | 6 | Priority bits of sources 0-5 |
| xc_byte_we | input | 1 | Byte write strobe of the added control register |
| xc_wdata | input | 8 | Byte write data |
| xc_bit_we | input | 1 | Single-bit write strobe |
| xc_bit_sel | input | 3 | Bit position for the single-bit write |
| xc_bit_val | input | 1 | Value for the single-bit write |
| xc_rdata | output | 8 | Current contents of the added control register |
| irq_req | output | 1 | A request is presented to the core |
| irq_vec | output | 8 | Vector address of the presented request |
| irq_ack | input | 1 | Core has entered the presented handler |
| irq_reti | input | 1 | Core has left the current handler |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser, vector base 3 and stride 8. Every source then maps to a small, fixed vector that the bench can predict arithmetically. All external sources are put in level mode, so each of the 256 pending patterns can be driven straight from the pins and timer inputs. That sweep is repeated under four priority patterns and each result is compared with a lowest-index winner computed in the bench. Directed sequences cover edge capture, flag clearing on acknowledge, software writes and nested preemption with returns.

// File: rtl/irq8_pkg.sv
// Shared constants and types for the eight-source interrupt controller.
// Assumes a fixed source count of eight with four external pins.
package irq8_pkg;
    localparam int NSRC  = 8;
    localparam int IDW   = $clog2(NSRC);
    localparam int NEXT  = 4;

    typedef logic [IDW-1:0] src_id_t;

    // Source index that each external pin feeds
    function automatic int ext_src(input int k);
        case (k)
            0:       return 0;
            1:       return 2;
            2:       return 6;
            default: return 7;
        endcase
    endfunction
endpackage

// File: rtl/irq8_sync_edge.sv
// Synchronises active-low external pins and flags falling edges.
// Assumes STAGES >= 2; chains reset to the idle (high) level.
module irq8_sync_edge #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_n,
    output logic [W-1:0] lvl_n,
    output logic [W-1:0] fall
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic [STAGES-1:0] chain;
        logic              prev;

        // Shift the pin through the synchroniser chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], pin_n[i]};
        end

        // Keep the previous synchronised sample for edge detection
        always_ff @(posedge clk) begin
            if (!rst_n) prev <= 1'b1;
            else        prev <= chain[STAGES-1];
        end

        assign lvl_n[i] = chain[STAGES-1];
        assign fall[i]  = prev & ~chain[STAGES-1];
    end
endmodule

// File: rtl/irq8_xctl.sv
// Holds the added control register and the pending flags of all four
// external sources. Edge mode latches flags; level mode tracks the pin.
// Assumes ack_valid is one cycle per accepted acknowledge.
module irq8_xctl
    import irq8_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      ext01_type,
    input  logic [NEXT-1:0] lvl_n,
    input  logic [NEXT-1:0] fall,
    input  logic            ack_valid,
    input  src_id_t         ack_id,
    input  logic            byte_we,
    input  logic [7:0]      wdata,
    input  logic            bit_we,
    input  logic [2:0]      bit_sel,
    input  logic            bit_val,
    output logic [7:0]      xreg,
    output logic [NEXT-1:0] ext_flag
);
    logic [7:0]      ctl_q;
    logic [7:0]      img;
    logic [NEXT-1:0] typ;
    logic [NEXT-1:0] flag_q;

    // Build the register image that a write in this cycle would leave
    always_comb begin
        img = xreg;
        if (byte_we) img = wdata;
        if (bit_we)  img[bit_sel] = bit_val;
    end

    // Store the non-flag control bits
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= img;
    end

    assign typ = {ctl_q[4], ctl_q[0], ext01_type};

    for (genvar k = 0; k < NEXT; k++) begin : g_flag
        localparam int      SRC  = ext_src(k);
        localparam int      FPOS = (k == 3) ? 5 : 1;
        logic sw_hit;
        logic ack_hit;

        if (k >= 2) begin : g_sw
            assign sw_hit = byte_we | (bit_we && bit_sel == 3'(FPOS));
        end else begin : g_nosw
            assign sw_hit = 1'b0;
        end
        assign ack_hit = ack_valid && ack_id == src_id_t'(SRC);

        // Update one pending flag from pin, software, acknowledge and edge
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[k] <= 1'b0;
            end else if (!typ[k]) begin
                flag_q[k] <= ~lvl_n[k];
            end else if (fall[k]) begin
                flag_q[k] <= 1'b1;
            end else if (ack_hit) begin
                flag_q[k] <= 1'b0;
            end else if (sw_hit) begin
                flag_q[k] <= img[FPOS];
            end
        end

        // R10: acknowledging an edge source without a new edge clears it
        a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_hit && typ[k] && !fall[k]) |=> !flag_q[k]);
        // R2: a detected edge in edge mode always leaves the flag set
        a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (typ[k] && fall[k]) |=> flag_q[k]);
    end

    assign xreg     = {ctl_q[7:6], flag_q[3], ctl_q[4:2], flag_q[2], ctl_q[0]};
    assign ext_flag = flag_q;
endmodule

// File: rtl/irq8_arbiter.sv
// Picks the next source: any allowed high-priority request first, then an
// allowed low-priority one; the lowest index wins inside a level.
// Pure combinational; assumes req is already masked by the enables.
module irq8_arbiter
    import irq8_pkg::*;
(
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] pri,
    input  logic            allow_hi,
    input  logic            allow_lo,
    output logic            valid,
    output src_id_t         id,
    output logic            hi
);
    logic [NSRC-1:0] hreq;
    logic [NSRC-1:0] lreq;
    src_id_t         hid;
    src_id_t         lid;

    assign hreq = req & pri;
    assign lreq = req & ~pri;

    // Find the lowest pending index inside each level
    always_comb begin
        hid = '0;
        lid = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (hreq[i]) hid = src_id_t'(i);
            if (lreq[i]) lid = src_id_t'(i);
        end
    end

    // Choose between the levels under the in-service limits
    always_comb begin
        valid = 1'b0;
        id    = '0;
        hi    = 1'b0;
        if (allow_hi && |hreq) begin
            valid = 1'b1;
            id    = hid;
            hi    = 1'b1;
        end else if (allow_lo && |lreq) begin
            valid = 1'b1;
            id    = lid;
        end
    end
endmodule

// File: rtl/irq8_level_stack.sv
// Records which priority levels have a handler in service and derives
// which levels may still be presented. Assumes push and pop never coincide.
module irq8_level_stack (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic push_hi,
    input  logic pop,
    output logic allow_hi,
    output logic allow_lo
);
    logic ins_hi;
    logic ins_lo;

    // Enter a level on acknowledge, leave the innermost level on return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_hi <= 1'b0;
            ins_lo <= 1'b0;
        end else if (push) begin
            if (push_hi) ins_hi <= 1'b1;
            else         ins_lo <= 1'b1;
        end else if (pop) begin
            if (ins_hi) ins_hi <= 1'b0;
            else        ins_lo <= 1'b0;
        end
    end

    assign allow_hi = ~ins_hi;
    assign allow_lo = ~ins_hi & ~ins_lo;

    // R8: a level is never entered while it or a higher one is in service
    a_r8_no_same_level: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !ins_hi && !(ins_lo && !push_hi));
    // R9: a return only arrives while some handler is in service
    a_r9_reti_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (ins_hi || ins_lo));
    // R9: acknowledge and return are never issued together
    a_r9_no_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
endmodule

// File: rtl/irq_ctrl8.sv
// Eight-source, two-level interrupt controller. Gathers external, timer and
// serial requests, arbitrates and presents a registered vector to the core.
// Assumes the core drives irq_ack only while irq_req is high and never
// drives irq_ack and irq_reti in the same cycle.
module irq_ctrl8
    import irq8_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] VEC_BASE    = 8'h03,
    parameter logic [7:0] VEC_STRIDE  = 8'd8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] ext_n,
    input  logic [2:0] tmr_req,
    input  logic       ser_req,
    input  logic [1:0] ext01_type,
    input  logic [7:0] ie_main,
    input  logic [5:0] ip_main,
    input  logic       xc_byte_we,
    input  logic [7:0] xc_wdata,
    input  logic       xc_bit_we,
    input  logic [2:0] xc_bit_sel,
    input  logic       xc_bit_val,
    output logic [7:0] xc_rdata,
    output logic       irq_req,
    output logic [7:0] irq_vec,
    input  logic       irq_ack,
    input  logic       irq_reti
);
    logic [NEXT-1:0] lvl_n;
    logic [NEXT-1:0] fall;
    logic [NEXT-1:0] ef;
    logic [7:0]      xr;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] ena;
    logic [NSRC-1:0] pri;
    logic            allow_hi;
    logic            allow_lo;
    logic            arb_valid;
    src_id_t         arb_id;
    logic            arb_hi;
    logic            cur_valid;
    src_id_t         cur_id;
    logic            cur_hi;
    logic            ack_valid;

    irq8_sync_edge #(.W(NEXT), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (ext_n),
        .lvl_n (lvl_n),
        .fall  (fall)
    );

    irq8_xctl xctl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext01_type (ext01_type),
        .lvl_n      (lvl_n),
        .fall       (fall),
        .ack_valid  (ack_valid),
        .ack_id     (cur_id),
        .byte_we    (xc_byte_we),
        .wdata      (xc_wdata),
        .bit_we     (xc_bit_we),
        .bit_sel    (xc_bit_sel),
        .bit_val    (xc_bit_val),
        .xreg       (xr),
        .ext_flag   (ef)
    );

    assign pend = {ef[3], ef[2], tmr_req[2], ser_req, tmr_req[1], ef[1], tmr_req[0], ef[0]};
    assign ena  = {xr[6], xr[2], ie_main[5:0]} & {NSRC{ie_main[7]}};
    assign pri  = {xr[7], xr[3], ip_main};

    irq8_arbiter arb_i (
        .req      (pend & ena),
        .pri      (pri),
        .allow_hi (allow_hi),
        .allow_lo (allow_lo),
        .valid    (arb_valid),
        .id       (arb_id),
        .hi       (arb_hi)
    );

    assign ack_valid = irq_ack & cur_valid;

    irq8_level_stack stack_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ack_valid),
        .push_hi  (cur_hi),
        .pop      (irq_reti),
        .allow_hi (allow_hi),
        .allow_lo (allow_lo)
    );

    // Register the arbitration result; drop it for a cycle on handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_valid <= 1'b0;
            cur_id    <= '0;
            cur_hi    <= 1'b0;
        end else begin
            cur_valid <= arb_valid & ~irq_ack & ~irq_reti;
            cur_id    <= arb_id;
            cur_hi    <= arb_hi;
        end
    end

    assign irq_req  = cur_valid;
    assign irq_vec  = cur_valid ? 8'(VEC_BASE + VEC_STRIDE * 8'(cur_id)) : 8'h00;
    assign xc_rdata = xr;

    // R12: an accepted acknowledge removes the request next cycle
    a_r12_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_req);
    // R7: nothing is presented unless the global enable was on
    a_r7_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(ie_main[7]));
    // R4: every presented vector lies on the base-plus-stride grid
    a_r4_vec_grid: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec >= VEC_BASE) && (((irq_vec - VEC_BASE) % VEC_STRIDE) == 8'd0));
    // R8: a high-priority presentation is never followed by one from a lower level without a handshake
    a_r8_no_hi_to_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && cur_hi && !irq_ack && !irq_reti && pend[cur_id] && ena[cur_id] && pri[cur_id])
        |=> !(irq_req && !cur_hi));
endmodule

// File: tb/irq_ctrl8_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl8_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] ext_n;
    logic [2:0] tmr_req;
    logic       ser_req;
    logic [1:0] ext01_type;
    logic [7:0] ie_main;
    logic [5:0] ip_main;
    logic       xc_byte_we;
    logic [7:0] xc_wdata;
    logic       xc_bit_we;
    logic [2:0] xc_bit_sel;
    logic       xc_bit_val;
    logic [7:0] xc_rdata;
    logic       irq_req;
    logic [7:0] irq_vec;
    logic       irq_ack;
    logic       irq_reti;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    irq_ctrl8 dut_i (
        .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .tmr_req(tmr_req),
        .ser_req(ser_req), .ext01_type(ext01_type), .ie_main(ie_main),
        .ip_main(ip_main), .xc_byte_we(xc_byte_we), .xc_wdata(xc_wdata),
        .xc_bit_we(xc_bit_we), .xc_bit_sel(xc_bit_sel), .xc_bit_val(xc_bit_val),
        .xc_rdata(xc_rdata), .irq_req(irq_req), .irq_vec(irq_vec),
        .irq_ack(irq_ack), .irq_reti(irq_reti)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Presented result: the vector, or 0x100 when nothing is requested
    function automatic int obs();
        return irq_req ? int'(irq_vec) : 'h100;
    endfunction

    // Expected presented vector from pending mask and priority mask
    function automatic int expect_vec(input logic [7:0] m, input logic [7:0] pm);
        logic [7:0] sel;
        sel = ((m & pm) != 0) ? (m & pm) : m;
        for (int i = 0; i < 8; i++) if (sel[i]) return 8 * i + 3;
        return 'h100;
    endfunction

    task automatic set_pend(input logic [7:0] m);
        ext_n[0]   = ~m[0];
        tmr_req[0] = m[1];
        ext_n[1]   = ~m[2];
        tmr_req[1] = m[3];
        ser_req    = m[4];
        tmr_req[2] = m[5];
        ext_n[2]   = ~m[6];
        ext_n[3]   = ~m[7];
    endtask

    task automatic wr_byte(input logic [7:0] v);
        xc_byte_we = 1'b1; xc_wdata = v;
        tick(1);
        xc_byte_we = 1'b0;
    endtask

    task automatic wr_bit(input int sel, input logic v);
        xc_bit_we = 1'b1; xc_bit_sel = 3'(sel); xc_bit_val = v;
        tick(1);
        xc_bit_we = 1'b0;
    endtask

    task automatic do_ack();
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
    endtask

    task automatic do_reti();
        irq_reti = 1'b1;
        tick(1);
        irq_reti = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; ext_n = 4'hF; tmr_req = '0; ser_req = 1'b0;
        ext01_type = 2'b00; ie_main = 8'h00; ip_main = '0;
        xc_byte_we = 1'b0; xc_wdata = '0; xc_bit_we = 1'b0;
        xc_bit_sel = '0; xc_bit_val = 1'b0; irq_ack = 1'b0; irq_reti = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R1 reset req/vec", obs(), 'h100);
        check("R1 reset xc_rdata", int'(xc_rdata), 0);

        // R7: global enable off blocks everything
        ie_main = 8'h7F;
        set_pend(8'h3F);
        tick(6);
        check("R7 global enable off", obs(), 'h100);
        ie_main = 8'hFD;
        set_pend(8'h02);
        tick(6);
        check("R7 source enable off", obs(), 'h100);
        set_pend(8'h00);
        ie_main = 8'hFF;
        tick(6);

        // R4 R5 R6: sweep all pending patterns under four priority patterns
        for (int p = 0; p < 4; p++) begin
            logic [7:0] pm;
            case (p)
                0: pm = 8'h00;
                1: pm = 8'hFF;
                2: pm = 8'h28;
                default: pm = 8'hC1;
            endcase
            ip_main = pm[5:0];
            wr_byte({pm[7], 1'b1, 2'b00, pm[6], 1'b1, 2'b00});
            for (int m = 0; m < 256; m++) begin
                set_pend(8'(m));
                tick(6);
                check($sformatf("R4 R5 R6 sweep pm=%0h m=%0h", pm, m),
                      obs(), expect_vec(8'(m), pm));
            end
        end
        set_pend(8'h00);
        wr_byte(8'h00);
        ip_main = '0;
        tick(6);

        // R2 R10: edge mode on external 2
        wr_byte(8'h05);
        tick(6);
        check("R2 idle flag", int'(xc_rdata[1]), 0);
        ext_n[2] = 1'b0;
        tick(6);
        check("R2 edge sets flag", int'(xc_rdata[1]), 1);
        check("R4 vector ext2", obs(), 'h33);
        do_ack();
        check("R12 req drops after ack", obs(), 'h100);
        tick(6);
        check("R10 ack clears edge flag", int'(xc_rdata[1]), 0);
        do_reti();
        tick(6);
        check("R2 held low no new edge", obs(), 'h100);

        // R3: level mode on external 2, acknowledge does not clear
        wr_byte(8'h04);
        tick(6);
        check("R3 level flag follows pin", int'(xc_rdata[1]), 1);
        check("R3 level request", obs(), 'h33);
        do_ack();
        tick(6);
        check("R3 ack leaves level flag", int'(xc_rdata[1]), 1);
        do_reti();
        tick(6);
        check("R3 level request again", obs(), 'h33);
        ext_n[2] = 1'b1;
        tick(6);
        check("R3 pin high clears flag", int'(xc_rdata[1]), 0);
        check("R3 no request", obs(), 'h100);

        // R11: software writes on external 3 in edge mode
        wr_byte(8'h10);
        wr_bit(5, 1'b1);
        tick(2);
        check("R11 bit write sets flag", int'(xc_rdata), 'h30);
        check("R11 disabled no request", obs(), 'h100);
        wr_bit(5, 1'b0);
        tick(2);
        check("R11 bit write clears flag", int'(xc_rdata), 'h10);
        wr_byte(8'h30);
        tick(2);
        check("R11 byte write sets flag", int'(xc_rdata), 'h30);
        wr_bit(6, 1'b1);
        tick(4);
        check("R11 bit write enable ext3", obs(), 'h3B);
        wr_byte(8'h00);
        tick(6);
        check("R11 byte write clears all", obs(), 'h100);

        // R8 R9: nesting with timer 0 low, timer 1 and timer 2 high
        ip_main = 6'b101000;
        tmr_req[0] = 1'b1;
        tick(4);
        check("R8 low request", obs(), 'h0B);
        do_ack();
        tmr_req[0] = 1'b0;
        tick(4);
        check("R12 no request after ack", obs(), 'h100);
        ser_req = 1'b1;
        tick(4);
        check("R8 same level blocked", obs(), 'h100);
        tmr_req[1] = 1'b1;
        tick(4);
        check("R8 high preempts low", obs(), 'h1B);
        do_ack();
        tmr_req[1] = 1'b0;
        tmr_req[2] = 1'b1;
        tick(4);
        check("R8 nothing over high", obs(), 'h100);
        do_reti();
        tick(4);
        check("R9 reti unblocks high", obs(), 'h2B);
        do_ack();
        tmr_req[2] = 1'b0;
        do_reti();
        tick(4);
        check("R9 low still in service", obs(), 'h100);
        do_reti();
        tick(4);
        check("R9 reti unblocks low", obs(), 'h23);
        do_ack();
        ser_req = 1'b0;
        do_reti();
        tick(4);
        check("R9 all idle", obs(), 'h100);

        finish_run();
    end
endmodule